// File: doc/BRIEF.md
# Converter sample and sequence controller

This block decides when an analog-to-digital converter samples and converts, and which result channel each conversion belongs to. A trigger is picked from a software start bit or one of seven hardware trigger lines and may be inverted. The sampling signal either follows that trigger level directly or is produced by an internal sampling timer that a trigger rising edge starts. When the sampling window closes, the controller raises a conversion request and holds it until the converter model answers with a done pulse.

Four sequence modes are supported: one conversion of one channel, one pass over a run of channels, endless repeats of one channel, and endless repeats of the channel run. A channel run starts at a programmable index and ends at the first channel whose end-of-sequence bit is set, or at the highest channel. Each conversion in a run needs its own trigger edge. Clearing the enable lets the current pass finish. Writing mode 00 while enabled aborts at once.

The mode is held in a small register that accepts writes only while the enable is low, except for the abort code. The other configuration inputs are expected to stay stable while the block is busy.

Top module: `adc_seq_ctrl`

## Requirements
- R1: After reset, busy_o, sampling_o and conv_req_o are 0, mode_o is 00 and channel_o equals start_ch_i.
- R2: trig_sel_i code 0 selects soft_start_i and code k (1 to 7) selects ext_trig_i[k-1]. invert_i = 1 inverts the selected line. A rising edge of the resulting trigger, while idle and enable_i = 1, raises sampling_o in the next cycle. Lines that are not selected have no effect.
- R3: With pulse_mode_i = 0, sampling_o stays high for as many cycles as the trigger stays high, starting one cycle after the rising edge. conv_req_o rises in the cycle in which sampling_o falls.
- R4: With pulse_mode_i = 1, sampling_o stays high for exactly sample_cycles_i + 1 cycles, however long the trigger stays high. conv_req_o rises in the cycle in which sampling_o falls.
- R5: conv_req_o stays high until conv_done_i is sampled high at a clock edge, and is low in the cycle after that edge.
- R6: Mode 00 converts channel start_ch_i once. busy_o is 0 in the cycle after the done.
- R7: Mode 01 converts start_ch_i, start_ch_i+1, and so on up to the first channel whose eos_mask_i bit is set (or channel NCH-1). Each channel takes its own trigger edge, busy_o stays 1 between channels, and busy_o returns to 0 after the last channel.
- R8: Mode 10 converts start_ch_i on every trigger. busy_o stays 1 between conversions while enable_i = 1.
- R9: Mode 11 repeats the channel run of R7. After the last channel, channel_o returns to start_ch_i and busy_o stays 1, waiting for the next trigger.
- R10: Clearing enable_i in a repeat mode lets the current pass finish (the current conversion in mode 10, the rest of the run in mode 11). After that, busy_o goes to 0. While waiting at a pass boundary with enable_i = 0, busy_o goes to 0 in the next cycle.
- R11: A mode write (mode codes: 00 single, 01 sequence, 10 repeat single, 11 repeat sequence) takes effect on mode_o after the write edge when enable_i = 0. A nonzero write while enable_i = 1 leaves mode_o unchanged.
- R12: Writing 00 while enable_i = 1 sets mode_o to 00 and drives busy_o, sampling_o and conv_req_o to 0 in the next cycle. This holds even when conv_done_i arrives in the same cycle.
- R13: Trigger edges are ignored while sampling or converting, and while idle with enable_i = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Conversion clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable_i | input | 1 | Conversion enable |
| mode_wr_i | input | 1 | Mode write strobe |
| mode_wdata_i | input | 2 | Mode write value |
| mode_o | output | 2 | Current sequence mode |
| trig_sel_i | input | 3 | Trigger source select |
| invert_i | input | 1 | Invert selected trigger |
| soft_start_i | input | 1 | Software start bit |
| ext_trig_i | input | 7 | Hardware trigger lines |
| pulse_mode_i | input | 1 | 1 = sampling timer, 0 = direct trigger level |
| sample_cycles_i | input | 8 | Sampling timer length minus one |
| start_ch_i | input | 4 | First channel of a pass |
| eos_mask_i | input | 16 | Per-channel end-of-sequence bits |
| sampling_o | output | 1 | Sampling signal |
| conv_req_o | output | 1 | Conversion request to converter |
| conv_done_i | input | 1 | Conversion done from converter |
| channel_o | output | 4 | Current channel index |
| busy_o | output | 1 | Sample, conversion or pass in progress |

## Verification
The abort write can land in the same cycle as a converter done, and both want to choose the next state. The bench provokes this by driving conv_done_i and a mode-00 write together while conv_req_o is high, in the middle of a sequence where the done alone would move to the next channel. It then expects busy_o and conv_req_o to be low and channel_o to be back at the start channel one cycle later. An abort is also issued in the middle of a long timer-driven sampling window. Random single and sequence passes, with random sources, polarities, timer lengths and end bits, are compared against channel lists and window lengths computed in the bench.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_ARMED  = 2'd1,
    ST_SAMPLE = 2'd2,
    ST_CONV   = 2'd3
  } seq_state_t;

  typedef enum logic [1:0] {
    MODE_SINGLE     = 2'b00,
    MODE_SEQ        = 2'b01,
    MODE_RPT_SINGLE = 2'b10,
    MODE_RPT_SEQ    = 2'b11
  } seq_mode_t;
endpackage

// File: rtl/adc_rst_sync.sv
module adc_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_sync = sync_q[1];
endmodule

// File: rtl/adc_trig_sel.sv
module adc_trig_sel #(
  parameter int NUM_EXT = 7,
  parameter int SEL_W   = $clog2(NUM_EXT + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               soft_i,
  input  logic [NUM_EXT-1:0] ext_i,
  input  logic [SEL_W-1:0]   sel_i,
  input  logic               invert_i,
  output logic               lvl_o,
  output logic               rise_o
);
  localparam int NSRC = NUM_EXT + 1;

  logic [NSRC-1:0] srcs;
  logic            lvl_q;

  assign srcs   = {ext_i, soft_i};
  assign lvl_o  = srcs[sel_i] ^ invert_i;
  assign rise_o = lvl_o & ~lvl_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lvl_q <= 1'b0;
    else        lvl_q <= lvl_o;
  end
endmodule

// File: rtl/adc_samp_timer.sv
module adc_samp_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic             run_i,
  input  logic [CNT_W-1:0] len_i,
  output logic             expired_o
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  assign expired_o = (cnt_q == '0);
  assign cnt_en    = load_i | (run_i & ~expired_o);

  always_comb begin
    cnt_d = cnt_q;
    if (load_i)     cnt_d = len_i;
    else if (run_i) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end
endmodule

// File: rtl/adc_mode_reg.sv
module adc_mode_reg
  import adc_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       enable_i,
  input  logic       wr_i,
  input  logic [1:0] wdata_i,
  output seq_mode_t  mode_o,
  output logic       abort_o
);
  seq_mode_t mode_q;
  logic      wr_en;

  assign abort_o = wr_i & enable_i & (wdata_i == 2'b00);
  assign wr_en   = wr_i & (~enable_i | (wdata_i == 2'b00));
  assign mode_o  = mode_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     mode_q <= MODE_SINGLE;
    else if (wr_en) mode_q <= seq_mode_t'(wdata_i);
  end

  // R11: a nonzero write while enabled leaves the mode unchanged
  assert_mode_locked_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (enable_i && wr_i && wdata_i != 2'b00) |=> $stable(mode_q));
endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
  import adc_seq_pkg::*;
#(
  parameter int NUM_EXT = 7,
  parameter int NCH     = 16,
  parameter int SHT_W   = 8,
  parameter int SEL_W   = $clog2(NUM_EXT + 1),
  parameter int CH_W    = $clog2(NCH)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               enable_i,
  input  logic               mode_wr_i,
  input  logic [1:0]         mode_wdata_i,
  output logic [1:0]         mode_o,
  input  logic [SEL_W-1:0]   trig_sel_i,
  input  logic               invert_i,
  input  logic               soft_start_i,
  input  logic [NUM_EXT-1:0] ext_trig_i,
  input  logic               pulse_mode_i,
  input  logic [SHT_W-1:0]   sample_cycles_i,
  input  logic [CH_W-1:0]    start_ch_i,
  input  logic [NCH-1:0]     eos_mask_i,
  output logic               sampling_o,
  output logic               conv_req_o,
  input  logic               conv_done_i,
  output logic [CH_W-1:0]    channel_o,
  output logic               busy_o
);
  localparam logic [CH_W-1:0] LAST_CH = CH_W'(NCH - 1);

  logic       rst_ns;
  logic       trig_lvl, trig_rise;
  logic       tmr_load, tmr_expired;
  logic       abort;
  seq_mode_t  mode_q;

  seq_state_t        state_q, state_d;
  logic [CH_W-1:0]   ch_q, ch_d;
  logic              pass_start_q, pass_start_d;
  logic              last_ch, sample_end;

  adc_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_ns)
  );

  adc_trig_sel #(.NUM_EXT(NUM_EXT), .SEL_W(SEL_W)) u_trig (
    .clk      (clk),
    .rst_n    (rst_ns),
    .soft_i   (soft_start_i),
    .ext_i    (ext_trig_i),
    .sel_i    (trig_sel_i),
    .invert_i (invert_i),
    .lvl_o    (trig_lvl),
    .rise_o   (trig_rise)
  );

  adc_samp_timer #(.CNT_W(SHT_W)) u_tmr (
    .clk       (clk),
    .rst_n     (rst_ns),
    .load_i    (tmr_load),
    .run_i     (state_q == ST_SAMPLE),
    .len_i     (sample_cycles_i),
    .expired_o (tmr_expired)
  );

  adc_mode_reg u_mode (
    .clk      (clk),
    .rst_n    (rst_ns),
    .enable_i (enable_i),
    .wr_i     (mode_wr_i),
    .wdata_i  (mode_wdata_i),
    .mode_o   (mode_q),
    .abort_o  (abort)
  );

  // single-channel modes end after one conversion; sequences end on an end bit
  assign last_ch    = ~mode_q[0] | eos_mask_i[ch_q] | (ch_q == LAST_CH);
  assign sample_end = pulse_mode_i ? tmr_expired : ~trig_lvl;

  always_comb begin
    state_d      = state_q;
    ch_d         = ch_q;
    pass_start_d = pass_start_q;
    tmr_load     = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        ch_d         = start_ch_i;
        pass_start_d = 1'b0;
        if (enable_i && trig_rise) begin
          state_d  = ST_SAMPLE;
          tmr_load = 1'b1;
        end
      end
      ST_ARMED: begin
        if (!enable_i && pass_start_q) begin
          state_d = ST_IDLE;
        end else if (trig_rise) begin
          state_d      = ST_SAMPLE;
          tmr_load     = 1'b1;
          pass_start_d = 1'b0;
        end
      end
      ST_SAMPLE: begin
        if (sample_end) state_d = ST_CONV;
      end
      ST_CONV: begin
        if (conv_done_i) begin
          if (last_ch) begin
            ch_d = start_ch_i;
            if (mode_q[1] && enable_i) begin
              state_d      = ST_ARMED;
              pass_start_d = 1'b1;
            end else begin
              state_d = ST_IDLE;
            end
          end else begin
            ch_d    = ch_q + 1'b1;
            state_d = ST_ARMED;
          end
        end
      end
    endcase
    if (abort) begin
      state_d      = ST_IDLE;
      ch_d         = start_ch_i;
      pass_start_d = 1'b0;
      tmr_load     = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) begin
      state_q      <= ST_IDLE;
      ch_q         <= '0;
      pass_start_q <= 1'b0;
    end else begin
      state_q      <= state_d;
      ch_q         <= ch_d;
      pass_start_q <= pass_start_d;
    end
  end

  assign sampling_o = (state_q == ST_SAMPLE);
  assign conv_req_o = (state_q == ST_CONV);
  assign busy_o     = (state_q != ST_IDLE);
  assign mode_o     = mode_q;
  assign channel_o  = (state_q == ST_IDLE) ? start_ch_i : ch_q;

  // R12: abort clears all activity on the next cycle
  assert_abort_clears_R12: assert property (@(posedge clk) disable iff (!rst_ns)
    abort |=> (!busy_o && !sampling_o && !conv_req_o));

  // R3 / R4: a conversion request always follows a sampling window
  assert_req_after_sample_R3: assert property (@(posedge clk) disable iff (!rst_ns)
    $rose(conv_req_o) |-> $past(sampling_o));

  // R5: request held until done
  assert_req_held_R5: assert property (@(posedge clk) disable iff (!rst_ns)
    (conv_req_o && !conv_done_i && !abort) |=> conv_req_o);

  // R6: single conversion mode goes idle after done
  assert_single_idle_R6: assert property (@(posedge clk) disable iff (!rst_ns)
    (conv_req_o && conv_done_i && mode_q == MODE_SINGLE) |=> !busy_o);

  // R8: single-channel modes never leave the start channel
  assert_single_channel_R8: assert property (@(posedge clk) disable iff (!rst_ns)
    (busy_o && !mode_q[0]) |-> (channel_o == start_ch_i));
endmodule

// File: tb/sim_adc_seq_ctrl.sv
module sim_adc_seq_ctrl;
  localparam int NCH = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        enable_i = 1'b0;
  logic        mode_wr_i = 1'b0;
  logic [1:0]  mode_wdata_i = 2'b00;
  logic [1:0]  mode_o;
  logic [2:0]  trig_sel_i = 3'd0;
  logic        invert_i = 1'b0;
  logic        soft_start_i = 1'b0;
  logic [6:0]  ext_trig_i = 7'd0;
  logic        pulse_mode_i = 1'b0;
  logic [7:0]  sample_cycles_i = 8'd0;
  logic [3:0]  start_ch_i = 4'd0;
  logic [15:0] eos_mask_i = 16'd0;
  logic        sampling_o, conv_req_o, conv_done_i = 1'b0, busy_o;
  logic [3:0]  channel_o;

  int checks = 0;
  int fails  = 0;
  logic done_flag = 1'b0;

  always #5 clk = ~clk;

  adc_seq_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .enable_i(enable_i), .mode_wr_i(mode_wr_i),
    .mode_wdata_i(mode_wdata_i), .mode_o(mode_o), .trig_sel_i(trig_sel_i),
    .invert_i(invert_i), .soft_start_i(soft_start_i), .ext_trig_i(ext_trig_i),
    .pulse_mode_i(pulse_mode_i), .sample_cycles_i(sample_cycles_i),
    .start_ch_i(start_ch_i), .eos_mask_i(eos_mask_i), .sampling_o(sampling_o),
    .conv_req_o(conv_req_o), .conv_done_i(conv_done_i), .channel_o(channel_o),
    .busy_o(busy_o)
  );

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic set_trig(input logic v);
    logic p;
    p = v ^ invert_i;
    if (trig_sel_i == 3'd0) soft_start_i = p;
    else ext_trig_i[int'(trig_sel_i) - 1] = p;
  endtask

  task automatic write_mode(input logic [1:0] m);
    mode_wr_i = 1'b1; mode_wdata_i = m;
    tick();
    mode_wr_i = 1'b0;
  endtask

  task automatic setup(input logic [1:0] m, input logic [2:0] sel, input logic inv,
                       input logic pm, input int n, input int st, input logic [15:0] eos);
    enable_i = 1'b0;
    write_mode(m);
    trig_sel_i = sel; invert_i = inv; pulse_mode_i = pm;
    sample_cycles_i = 8'(n); start_ch_i = 4'(st); eos_mask_i = eos;
    soft_start_i = inv; ext_trig_i = {7{inv}};
    tick(); tick();
  endtask

  // one trigger, waits for the request; returns channel and window length
  task automatic sample_once(input int hold, output int ch, output int len);
    bit got;
    got = 1'b0; len = 0; ch = -1;
    set_trig(1'b1);
    for (int i = 0; i < 300; i++) begin
      tick();
      if (i == hold - 1) set_trig(1'b0);
      if (sampling_o) len++;
      if (conv_req_o) begin got = 1'b1; break; end
    end
    set_trig(1'b0);
    if (got) ch = int'(channel_o);
  endtask

  task automatic finish_conv();
    conv_done_i = 1'b1;
    tick();
    conv_done_i = 1'b0;
  endtask

  function automatic int last_of(input int st, input logic [15:0] eos, input logic seqm);
    if (!seqm) return st;
    for (int c = st; c < NCH; c++) if (eos[c] || c == NCH - 1) return c;
    return NCH - 1;
  endfunction

  initial begin
    int ch, len, lst, n, st, hold;
    logic [1:0] m;
    logic [15:0] eos;
    void'($urandom(32'h5EED));

    #23 rst_n = 1'b1;
    tick(); tick(); tick();
    // R1 reset state
    chk(!busy_o && !sampling_o && !conv_req_o, "R1 idle outputs", int'(busy_o), 0);
    chk(mode_o == 2'b00, "R1 mode", int'(mode_o), 0);
    chk(channel_o == start_ch_i, "R1 channel", int'(channel_o), int'(start_ch_i));

    // R11 writes while disabled take effect, nonzero writes while enabled do not
    write_mode(2'b01);
    chk(mode_o == 2'b01, "R11 write disabled", int'(mode_o), 1);
    enable_i = 1'b1;
    write_mode(2'b11);
    chk(mode_o == 2'b01, "R11 write enabled ignored", int'(mode_o), 1);
    enable_i = 1'b0;

    // R3 / R6 direct mode single conversion
    setup(2'b00, 3'd0, 1'b0, 1'b0, 0, 3, 16'h0);
    enable_i = 1'b1; tick();
    sample_once(3, ch, len);
    chk(len == 3, "R3 direct window", len, 3);
    chk(ch == 3, "R6 channel", ch, 3);
    tick(); tick(); tick();
    chk(conv_req_o, "R5 request held", int'(conv_req_o), 1);
    finish_conv();
    chk(!conv_req_o, "R5 request drops", int'(conv_req_o), 0);
    chk(!busy_o, "R6 idle after single", int'(busy_o), 0);

    // R13 trigger ignored while disabled
    enable_i = 1'b0; tick();
    set_trig(1'b1); tick(); tick();
    chk(!busy_o && !sampling_o, "R13 disabled trigger", int'(busy_o), 0);
    set_trig(1'b0); tick();

    // R2 unselected line ignored, selected inverted ext line used; R4 timer
    setup(2'b00, 3'd3, 1'b1, 1'b1, 5, 1, 16'h0);
    enable_i = 1'b1; tick();
    ext_trig_i[0] = 1'b0; tick(); tick();
    chk(!busy_o, "R2 unselected ignored", int'(busy_o), 0);
    ext_trig_i[0] = 1'b1; tick();
    sample_once(1, ch, len);
    chk(len == 6, "R4 timer window", len, 6);
    chk(ch == 1, "R2 ext inverted start", ch, 1);
    // R13 trigger during conversion ignored
    set_trig(1'b1); tick(); set_trig(1'b0); tick();
    finish_conv();
    chk(!busy_o && !sampling_o, "R13 trigger in conversion ignored", int'(busy_o), 0);

    // R7 sequence 2..4
    setup(2'b01, 3'd0, 1'b0, 1'b0, 0, 2, 16'h0010);
    enable_i = 1'b1; tick();
    for (int k = 2; k <= 4; k++) begin
      sample_once(1, ch, len);
      chk(ch == k, "R7 sequence channel", ch, k);
      finish_conv();
      if (k < 4) chk(busy_o, "R7 busy between", int'(busy_o), 1);
    end
    chk(!busy_o, "R7 idle after pass", int'(busy_o), 0);

    // R8 repeat single, then R10 disable at boundary
    setup(2'b10, 3'd5, 1'b0, 1'b1, 2, 9, 16'h0);
    enable_i = 1'b1; tick();
    for (int k = 0; k < 3; k++) begin
      sample_once(1, ch, len);
      chk(ch == 9 && len == 3, "R8 repeat single", ch, 9);
      finish_conv();
      chk(busy_o, "R8 busy between repeats", int'(busy_o), 1);
    end
    enable_i = 1'b0; tick();
    chk(!busy_o, "R10 disable at boundary", int'(busy_o), 0);

    // R9 repeat sequence wrap, then R10 disable mid pass
    setup(2'b11, 3'd0, 1'b0, 1'b0, 0, 5, 16'h0040);
    enable_i = 1'b1; tick();
    for (int k = 5; k <= 6; k++) begin
      sample_once(2, ch, len);
      chk(ch == k, "R9 channel", ch, k);
      finish_conv();
    end
    chk(busy_o && channel_o == 4'd5, "R9 wrap to start", int'(channel_o), 5);
    sample_once(1, ch, len);
    finish_conv();
    enable_i = 1'b0; tick();
    chk(busy_o, "R10 pass continues", int'(busy_o), 1);
    sample_once(1, ch, len);
    chk(ch == 6, "R10 finishing channel", ch, 6);
    finish_conv();
    chk(!busy_o, "R10 idle after pass", int'(busy_o), 0);

    // R12 abort during a long timer window
    setup(2'b11, 3'd0, 1'b0, 1'b1, 20, 0, 16'h0008);
    enable_i = 1'b1; tick();
    set_trig(1'b1); tick(); tick(); tick();
    chk(sampling_o, "R12 sampling before abort", int'(sampling_o), 1);
    write_mode(2'b00);
    chk(!busy_o && !sampling_o && mode_o == 2'b00, "R12 abort sampling", int'(busy_o), 0);
    set_trig(1'b0); tick();

    // R12 abort in the same cycle as done, mid sequence
    enable_i = 1'b0;
    setup(2'b01, 3'd0, 1'b0, 1'b0, 0, 4, 16'h0080);
    enable_i = 1'b1; tick();
    sample_once(1, ch, len);
    conv_done_i = 1'b1; mode_wr_i = 1'b1; mode_wdata_i = 2'b00;
    tick();
    conv_done_i = 1'b0; mode_wr_i = 1'b0;
    chk(!busy_o && !conv_req_o, "R12 abort with done", int'(busy_o), 0);
    chk(channel_o == 4'd4, "R12 channel after abort", int'(channel_o), 4);

    // random passes in modes 00 / 01
    for (int it = 0; it < 40; it++) begin
      m    = 2'($urandom_range(0, 1));
      st   = int'($urandom_range(0, NCH - 1));
      eos  = 16'($urandom);
      n    = int'($urandom_range(0, 7));
      hold = int'($urandom_range(1, 5));
      setup(m, 3'($urandom_range(0, 7)), 1'($urandom_range(0, 1)),
            1'($urandom_range(0, 1)), n, st, eos);
      enable_i = 1'b1; tick();
      lst = last_of(st, eos, m[0]);
      for (int c = st; c <= lst; c++) begin
        sample_once(hold, ch, len);
        chk(ch == c, m[0] ? "R7 random channel" : "R6 random channel", ch, c);
        chk(len == (pulse_mode_i ? n + 1 : hold), "R4 random window", len,
            pulse_mode_i ? n + 1 : hold);
        finish_conv();
      end
      chk(!busy_o, "R6 random idle", int'(busy_o), 0);
      enable_i = 1'b0;
    end

    done_flag = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done_flag) begin
      checks++; fails++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule